// File: doc/BRIEF.md
# Multi-Line Atomic Event Monitor

This block decides whether a multi-location atomic event succeeds. While the event is open, the core names the lines that take part with locked loads or locked prefetches. Each named line takes one slot in a small table of line-address monitors. Stores to those lines are not sent to memory. They are held in a per-line write buffer, and later loads from those lines get the buffered data back. Every other access goes straight to memory. These pass-through accesses are not limited in number and are never undone.

Coherence snoops from other agents are compared against the monitored lines. A hit sets an interference flag, which software can read with a query operation. The event ends with a locked store. If that store targets a monitored line and no interference has been seen, the block opens its commit port for a single cycle. In that cycle it presents every buffered line write at once and holds off snoops, so no other agent can see part of the update. In every other case the buffered writes are dropped.

A control transfer (interrupt, exception, supervisor call or return) or a privilege change also drops the buffered writes and asks the core to restart the event. Every outcome is reported with a one-cycle done pulse and a success bit, after which all monitors are free again.

Top module: `atomic_event_monitor`

## Requirements
- R1: After reset the block is idle: `done`, `success`, `restart` and `cm_valid` are 0, `snp_ready` and `req_ready` are 1, and `rsp_interf` is 0.
- R2: Line identity is `addr[31:6]`, so the low 6 address bits are ignored. A locked access to a line that is already monitored reuses its slot. `cm_addr` slot k holds the k-th distinct line joined, and `cm_data`/`cm_mask` bit k belong to the same slot.
- R3: If a locked load or locked prefetch would add a ninth distinct line, the event fails. In the next cycle `done`=1 and `success`=0, with no commit.
- R4: A plain load, or a plain store to a line that is not monitored, drives `pt_valid` in the same cycle (`pt_we`=1 for stores). Such accesses do not take a monitor slot, and any number of them may be made.
- R5: A plain or locked store to a monitored line is buffered. It does not raise `pt_valid`.
- R6: A load (op 0 or 2) to a monitored line that has a buffered write returns the buffered data on `rsp_data` in the same cycle. Otherwise `rsp_data` equals `pt_rdata`.
- R7: A snoop accepted while `snp_ready`=1 whose line matches a monitored line sets the interference flag. Snoops to other lines do not set it. The query op (5) sees the flag on `rsp_interf`.
- R8: A locked store (op 4) to a monitored line with no interference, where a snoop hit in the same cycle also counts as interference, leads in the next cycle to `cm_valid`=1 for exactly one cycle, together with `done`=1 and `success`=1. In that cycle `cm_mask` has one bit set per buffered slot.
- R9: `snp_ready` is 0 exactly in the commit cycle.
- R10: A concluding locked store that sees interference gives `done`=1 and `success`=0 in the next cycle, with no commit.
- R11: A locked store to a line that is not monitored, whether an event is open or not, ends the event as a failure. That store is not passed to memory.
- R12: A control transfer (`ctl_xfer`) or privilege change (`priv_chg`) during an open event drops the request of that cycle (`req_ready`=0). The next cycle shows `done`=1, `success`=0 and `restart`=1, and the buffered writes are discarded.
- R13: After any outcome all monitors, buffered data and the interference flag are cleared. The following event sees none of them.
- Op codes on `req_op`: 0 load, 1 store, 2 locked load, 3 locked prefetch, 4 locked store, 5 query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data (line payload) |
| rsp_data | output | 32 | Load data, same cycle |
| rsp_interf | output | 1 | Interference flag for query |
| pt_valid | output | 1 | Pass-through memory access |
| pt_we | output | 1 | Pass-through write enable |
| pt_addr | output | 32 | Pass-through address |
| pt_wdata | output | 32 | Pass-through write data |
| pt_rdata | input | 32 | Pass-through read data |
| snp_valid | input | 1 | Snoop present |
| snp_addr | input | 32 | Snoop address |
| snp_ready | output | 1 | Snoop accepted |
| ctl_xfer | input | 1 | Interrupt, exception or supervisor call/return |
| priv_chg | input | 1 | Privilege-level change |
| cm_valid | output | 1 | Single commit strobe |
| cm_mask | output | 8 | Slots holding a write |
| cm_addr | output | 208 | Line address per slot |
| cm_data | output | 256 | Payload per slot |
| done | output | 1 | Outcome pulse |
| success | output | 1 | Outcome was a commit |
| restart | output | 1 | Core must restart the event |

## Verification
The table of monitors and the write buffer are internal state, so the bench detects their faults through the effects they have on the ports. A slot that was not reused, or a count that is off, shows up as a wrong `cm_mask` or a missed or early overflow failure. A stale buffered entry or interference flag left over from an earlier event shows up in the very next event, as forwarded data where memory data was expected or as a failed commit. Every outcome is visible on `done`/`success` one cycle after the cause, and the bench samples at exactly that cycle.

// File: rtl/aem_pkg.sv
package aem_pkg;

   typedef enum logic [2:0] {
      OP_LOAD   = 3'd0,
      OP_STORE  = 3'd1,
      OP_LLOAD  = 3'd2,
      OP_LPREF  = 3'd3,
      OP_LSTORE = 3'd4,
      OP_QUERY  = 3'd5
   } aem_op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_COMMIT = 2'd2,
      ST_FAIL   = 2'd3
   } aem_state_e;

endpackage

// File: rtl/aem_line_table.sv
module aem_line_table #(
   parameter int MAX_LINES = 8,
   parameter int TAG_W     = 26
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       alloc,
   input  logic [TAG_W-1:0]           alloc_tag,
   input  logic [TAG_W-1:0]           q_tag,
   output logic                       q_hit,
   output logic [((MAX_LINES>1)?$clog2(MAX_LINES):1)-1:0] q_idx,
   input  logic [TAG_W-1:0]           s_tag,
   output logic                       s_hit,
   output logic                       full,
   output logic [MAX_LINES*TAG_W-1:0] tags_flat
);
   localparam int IDX_W = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;
   localparam int CNT_W = $clog2(MAX_LINES + 1);

   logic [CNT_W-1:0]     cnt_q;
   logic [MAX_LINES-1:0] valid_q;
   logic [TAG_W-1:0]     tag_q [MAX_LINES];
   logic [MAX_LINES-1:0] q_match, s_match;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q   <= '0;
         valid_q <= '0;
      end else if (alloc) begin
         cnt_q                   <= cnt_q + 1'b1;
         valid_q[cnt_q[IDX_W-1:0]] <= 1'b1;
      end
   end

   for (genvar i = 0; i < MAX_LINES; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            tag_q[i] <= '0;
         else if (alloc && cnt_q[IDX_W-1:0] == IDX_W'(i))
            tag_q[i] <= alloc_tag;
      end
      assign q_match[i] = valid_q[i] && (tag_q[i] == q_tag);
      assign s_match[i] = valid_q[i] && (tag_q[i] == s_tag);
      assign tags_flat[i*TAG_W +: TAG_W] = tag_q[i];
   end

   always_comb begin
      q_idx = '0;
      for (int i = 0; i < MAX_LINES; i++)
         if (q_match[i]) q_idx = IDX_W'(i);
   end

   assign q_hit = |q_match;
   assign s_hit = |s_match;
   assign full  = (cnt_q == CNT_W'(MAX_LINES));
endmodule

// File: rtl/aem_write_buffer.sv
module aem_write_buffer #(
   parameter int MAX_LINES = 8,
   parameter int DATA_W    = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        wr_en,
   input  logic [((MAX_LINES>1)?$clog2(MAX_LINES):1)-1:0] wr_idx,
   input  logic [DATA_W-1:0]           wr_data,
   input  logic [((MAX_LINES>1)?$clog2(MAX_LINES):1)-1:0] rd_idx,
   output logic                        rd_dirty,
   output logic [DATA_W-1:0]           rd_data,
   output logic [MAX_LINES-1:0]        dirty,
   output logic [MAX_LINES*DATA_W-1:0] data_flat
);
   localparam int IDX_W = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;

   logic [DATA_W-1:0] data_q [MAX_LINES];

   for (genvar i = 0; i < MAX_LINES; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            dirty[i]  <= 1'b0;
            data_q[i] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            dirty[i]  <= 1'b1;
            data_q[i] <= wr_data;
         end
      end
      assign data_flat[i*DATA_W +: DATA_W] = data_q[i];
   end

   assign rd_dirty = dirty[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/atomic_event_monitor.sv
module atomic_event_monitor
   import aem_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_LINES  = 8,
   parameter bit FWD_EN     = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [2:0]                  req_op,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   output logic [DATA_W-1:0]           rsp_data,
   output logic                        rsp_interf,
   output logic                        pt_valid,
   output logic                        pt_we,
   output logic [ADDR_W-1:0]           pt_addr,
   output logic [DATA_W-1:0]           pt_wdata,
   input  logic [DATA_W-1:0]           pt_rdata,
   input  logic                        snp_valid,
   input  logic [ADDR_W-1:0]           snp_addr,
   output logic                        snp_ready,
   input  logic                        ctl_xfer,
   input  logic                        priv_chg,
   output logic                        cm_valid,
   output logic [MAX_LINES-1:0]        cm_mask,
   output logic [MAX_LINES*(ADDR_W-$clog2(LINE_BYTES))-1:0] cm_addr,
   output logic [MAX_LINES*DATA_W-1:0] cm_data,
   output logic                        done,
   output logic                        success,
   output logic                        restart
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int TAG_W = ADDR_W - OFF_W;
   localparam int IDX_W = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1;

   if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two above 1");
   end
   if (MAX_LINES < 1 || MAX_LINES > 64) begin : g_bad_depth
      $error("MAX_LINES out of range");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W too small for the line size");
   end

   aem_state_e state_q, state_d;
   logic       interf_q, restart_q, restart_d;

   aem_op_e    op;
   logic [TAG_W-1:0] req_tag, snp_tag;
   logic       acc, in_evt, abort, is_acq, is_load, is_store, part;
   logic       q_hit, s_hit, full, alloc, overflow, snoop_hit, wr_en, clr;
   logic [IDX_W-1:0] q_idx;
   logic       rd_dirty;
   logic [DATA_W-1:0] rd_data;
   logic [MAX_LINES-1:0] dirty;

   assign op       = aem_op_e'(req_op);
   assign req_tag  = req_addr[ADDR_W-1:OFF_W];
   assign snp_tag  = snp_addr[ADDR_W-1:OFF_W];
   assign in_evt   = (state_q == ST_ACTIVE);
   assign abort    = in_evt && (ctl_xfer || priv_chg);
   assign req_ready = ((state_q == ST_IDLE) || in_evt) && !abort;
   assign acc      = req_valid && req_ready;
   assign is_acq   = (op == OP_LLOAD) || (op == OP_LPREF);
   assign is_load  = (op == OP_LOAD) || (op == OP_LLOAD);
   assign is_store = (op == OP_STORE) || (op == OP_LSTORE);
   assign part     = in_evt && q_hit;
   assign overflow = acc && is_acq && !q_hit && full;
   assign alloc    = acc && is_acq && !q_hit && !full;
   assign wr_en    = acc && is_store && part;
   assign snp_ready = (state_q != ST_COMMIT);
   assign snoop_hit = in_evt && snp_valid && snp_ready && s_hit;
   assign clr      = (state_q == ST_COMMIT) || (state_q == ST_FAIL);

   aem_line_table #(.MAX_LINES(MAX_LINES), .TAG_W(TAG_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .alloc     (alloc),
      .alloc_tag (req_tag),
      .q_tag     (req_tag),
      .q_hit     (q_hit),
      .q_idx     (q_idx),
      .s_tag     (snp_tag),
      .s_hit     (s_hit),
      .full      (full),
      .tags_flat (cm_addr)
   );

   aem_write_buffer #(.MAX_LINES(MAX_LINES), .DATA_W(DATA_W)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .wr_en     (wr_en),
      .wr_idx    (q_idx),
      .wr_data   (req_wdata),
      .rd_idx    (q_idx),
      .rd_dirty  (rd_dirty),
      .rd_data   (rd_data),
      .dirty     (dirty),
      .data_flat (cm_data)
   );

   // pass-through path: loads always read memory; stores only when off-event-line
   assign pt_valid = acc && (is_load || (op == OP_STORE && !part));
   assign pt_we    = (op == OP_STORE);
   assign pt_addr  = req_addr;
   assign pt_wdata = req_wdata;

   if (FWD_EN) begin : g_fwd
      assign rsp_data = (is_load && part && rd_dirty) ? rd_data : pt_rdata;
   end else begin : g_nofwd
      logic unused_fwd;
      assign unused_fwd = rd_dirty ^ (|rd_data);
      assign rsp_data   = pt_rdata;
   end

   assign rsp_interf = interf_q;

   always_comb begin
      state_d   = state_q;
      restart_d = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (acc && is_acq)             state_d = ST_ACTIVE;
            else if (acc && op == OP_LSTORE) state_d = ST_FAIL;
         end
         ST_ACTIVE: begin
            if (abort) begin
               state_d   = ST_FAIL;
               restart_d = 1'b1;
            end else if (overflow) begin
               state_d = ST_FAIL;
            end else if (acc && op == OP_LSTORE) begin
               if (part && !interf_q && !snoop_hit) state_d = ST_COMMIT;
               else                                 state_d = ST_FAIL;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         interf_q  <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         restart_q <= restart_d;
         if (clr)            interf_q <= 1'b0;
         else if (snoop_hit) interf_q <= 1'b1;
      end
   end

   assign cm_valid = (state_q == ST_COMMIT);
   assign cm_mask  = cm_valid ? dirty : '0;
   assign done     = clr;
   assign success  = cm_valid;
   assign restart  = restart_q;
endmodule

// File: rtl/aem_checker.sv
module aem_checker #(
   parameter int MAX_LINES = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic [2:0] req_op,
   input logic       pt_valid,
   input logic       pt_we,
   input logic       snp_ready,
   input logic       cm_valid,
   input logic [MAX_LINES-1:0] cm_mask,
   input logic       done,
   input logic       success,
   input logic       restart
);
   a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
      cm_valid |=> !cm_valid);
   a_r8_commit_reports: assert property (@(posedge clk) disable iff (!rst_n)
      cm_valid |-> (done && success));
   a_r9_snoop_held: assert property (@(posedge clk) disable iff (!rst_n)
      cm_valid |-> !snp_ready);
   a_r10_fail_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !success) |-> (!cm_valid && cm_mask == '0));
   a_r11_lock_store_not_passed: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op == 3'd4) |-> !pt_valid);
   a_r4_pt_write_plain_only: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_valid && pt_we) |-> (req_valid && req_ready && req_op == 3'd1));
   a_r12_restart_is_failure: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (done && !success));
   a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind atomic_event_monitor aem_checker #(.MAX_LINES(MAX_LINES)) u_aem_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .pt_valid  (pt_valid),
   .pt_we     (pt_we),
   .snp_ready (snp_ready),
   .cm_valid  (cm_valid),
   .cm_mask   (cm_mask),
   .done      (done),
   .success   (success),
   .restart   (restart)
);

// File: tb/tb_atomic_event_monitor.sv
module tb_atomic_event_monitor;
   localparam int MAXL  = 8;
   localparam int TAG_W = 26;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [2:0] req_op = 3'd0;
   logic [31:0] req_addr = '0, req_wdata = '0, rsp_data;
   logic rsp_interf, pt_valid, pt_we;
   logic [31:0] pt_addr, pt_wdata, pt_rdata;
   logic snp_valid = 1'b0, snp_ready;
   logic [31:0] snp_addr = '0;
   logic ctl_xfer = 1'b0, priv_chg = 1'b0;
   logic cm_valid, done, success, restart;
   logic [MAXL-1:0] cm_mask;
   logic [MAXL*TAG_W-1:0] cm_addr;
   logic [MAXL*32-1:0] cm_data;

   int n_chk = 0, n_fail = 0;

   // comb samples (during request) and post-edge samples
   logic s_ready, s_ptv, s_ptwe, s_interf;
   logic [31:0] s_rsp;

   always #10 clk = ~clk;

   function automatic logic [31:0] memval(input logic [31:0] a);
      return {a[31:6], 6'd0} ^ 32'h5A5A_0000;
   endfunction
   assign pt_rdata = memval(pt_addr);

   atomic_event_monitor dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_data(rsp_data), .rsp_interf(rsp_interf), .pt_valid(pt_valid),
      .pt_we(pt_we), .pt_addr(pt_addr), .pt_wdata(pt_wdata), .pt_rdata(pt_rdata),
      .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_ready(snp_ready),
      .ctl_xfer(ctl_xfer), .priv_chg(priv_chg), .cm_valid(cm_valid),
      .cm_mask(cm_mask), .cm_addr(cm_addr), .cm_data(cm_data), .done(done),
      .success(success), .restart(restart));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle: inputs driven after negedge, comb sampled, registered sampled after edge
   task automatic cyc(input logic v, input logic [2:0] op, input logic [31:0] a,
                      input logic [31:0] d, input logic sv, input logic [31:0] sa,
                      input logic x, input logic p);
      @(negedge clk);
      req_valid = v; req_op = op; req_addr = a; req_wdata = d;
      snp_valid = sv; snp_addr = sa; ctl_xfer = x; priv_chg = p;
      #2;
      s_ready = req_ready; s_ptv = pt_valid; s_ptwe = pt_we;
      s_rsp = rsp_data; s_interf = rsp_interf;
      @(posedge clk);
      #1;
      req_valid = 1'b0; snp_valid = 1'b0; ctl_xfer = 1'b0; priv_chg = 1'b0;
   endtask

   task automatic rq(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d);
      cyc(1'b1, op, a, d, 1'b0, '0, 1'b0, 1'b0);
   endtask

   function automatic logic [31:0] laddr(input int n, input int k);
      return 32'h1000_0000 + 32'(n) * 32'h1_0000 + 32'(k) * 64 + 32'((k * 4) % 64);
   endfunction

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #2;
      // R1 reset state
      chk(!done && !success && !restart && !cm_valid, "R1 outcome idle",
          {done, success, restart, cm_valid}, 0);
      chk(snp_ready && req_ready && !rsp_interf, "R1 ready/interf",
          {snp_ready, req_ready, rsp_interf}, 3'b110);

      // Sweep: events with n = 1..8 lines, each line stored, committed (R2 R5 R6 R8 R9)
      for (int n = 1; n <= MAXL; n++) begin
         for (int k = 0; k < n; k++) rq(3'd2, laddr(n, k), '0);
         // reuse: locked prefetch of line 0 at another offset (R2)
         rq(3'd3, laddr(n, 0) + 32'd60 - 32'((0 * 4) % 64), '0);
         chk(!done, "R2 reuse keeps event open", done, 0);
         for (int k = 0; k < n; k++) begin
            rq(3'd1, laddr(n, k) ^ 32'h3C, 32'hC000_0000 + 32'(n * 256 + k));
            chk(!s_ptv, "R5 buffered store not passed", s_ptv, 0);
         end
         for (int k = 0; k < n; k++) begin
            rq(3'd0, laddr(n, k), '0);
            chk(s_rsp == 32'hC000_0000 + 32'(n * 256 + k), "R6 forwarded data",
                s_rsp, 32'hC000_0000 + 32'(n * 256 + k));
         end
         #2;
         chk(snp_ready, "R9 snoop ready before commit", snp_ready, 1);
         rq(3'd4, laddr(n, n - 1), 32'hE000_0000 + 32'(n));
         #2;
         chk(cm_valid && done && success, "R8 commit strobe",
             {cm_valid, done, success}, 3'b111);
         chk(!snp_ready, "R9 snoop held in commit", snp_ready, 0);
         chk(cm_mask == MAXL'((1 << n) - 1), "R8 commit mask", cm_mask, (1 << n) - 1);
         for (int k = 0; k < n; k++) begin
            logic [31:0] expd;
            expd = (k == n - 1) ? 32'hE000_0000 + 32'(n) : 32'hC000_0000 + 32'(n * 256 + k);
            chk(cm_addr[k*TAG_W +: TAG_W] == laddr(n, k) >> 6, "R2 slot line",
                cm_addr[k*TAG_W +: TAG_W], laddr(n, k) >> 6);
            chk(cm_data[k*32 +: 32] == expd, "R8 slot data", cm_data[k*32 +: 32], expd);
         end
         @(posedge clk); #1;
         chk(!cm_valid && !done && snp_ready, "R8 one-cycle commit",
             {cm_valid, done, snp_ready}, 3'b001);
      end

      // R3 ninth line fails
      for (int k = 0; k < MAXL; k++) rq(3'd2, laddr(20, k), '0);
      chk(!done, "R3 eight lines accepted", done, 0);
      rq(3'd3, laddr(20, MAXL), '0);
      #2;
      chk(done && !success && !cm_valid, "R3 ninth line fails",
          {done, success, cm_valid}, 3'b100);
      @(posedge clk); #1;

      // R4 unlimited pass-through traffic, not counted
      rq(3'd2, laddr(21, 0), '0);
      for (int i = 0; i < 20; i++) begin
         rq(3'd1, 32'h2000_0000 + 32'(i) * 64, 32'(i));
         chk(s_ptv && s_ptwe, "R4 plain store passed", {s_ptv, s_ptwe}, 2'b11);
      end
      rq(3'd0, 32'h3000_0040, '0);
      chk(s_ptv && !s_ptwe && s_rsp == memval(32'h3000_0040), "R4 plain load",
          s_rsp, memval(32'h3000_0040));
      for (int k = 1; k < MAXL; k++) rq(3'd2, laddr(21, k), '0);
      rq(3'd4, laddr(21, 3), 32'h77);
      #2;
      chk(done && success && cm_mask == 8'h08, "R4 no slots used by plain traffic",
          {done, success, cm_mask}, {2'b11, 8'h08});
      @(posedge clk); #1;

      // R7 snoop to other line does not interfere; R10 snoop hit fails event
      rq(3'd2, laddr(22, 0), '0);
      rq(3'd1, laddr(22, 0), 32'h55);
      cyc(1'b0, 3'd0, '0, '0, 1'b1, laddr(23, 0), 1'b0, 1'b0);
      rq(3'd5, '0, '0);
      chk(!s_interf, "R7 unrelated snoop", s_interf, 0);
      cyc(1'b0, 3'd0, '0, '0, 1'b1, laddr(22, 0) | 32'h3F, 1'b0, 1'b0);
      rq(3'd5, '0, '0);
      chk(s_interf, "R7 snoop hit seen by query", s_interf, 1);
      rq(3'd4, laddr(22, 0), 32'h66);
      #2;
      chk(done && !success && !cm_valid, "R10 interference fails",
          {done, success, cm_valid}, 3'b100);
      @(posedge clk); #1;

      // R10 snoop hit in the same cycle as the closing store
      rq(3'd2, laddr(24, 0), '0);
      cyc(1'b1, 3'd4, laddr(24, 0), 32'h1, 1'b1, laddr(24, 0), 1'b0, 1'b0);
      #2;
      chk(done && !success, "R10 same-cycle snoop fails", {done, success}, 2'b10);
      @(posedge clk); #1;

      // R11 locked store to non-participating line
      rq(3'd2, laddr(25, 0), '0);
      rq(3'd4, laddr(25, 1), 32'h9);
      chk(!s_ptv, "R11 store not performed", s_ptv, 0);
      #2;
      chk(done && !success && !cm_valid, "R11 abandon", {done, success, cm_valid}, 3'b100);
      @(posedge clk); #1;
      rq(3'd4, laddr(25, 2), 32'h9);
      #2;
      chk(done && !success && !cm_valid, "R11 idle locked store",
          {done, success, cm_valid}, 3'b100);
      @(posedge clk); #1;

      // R12 control transfer and privilege change
      rq(3'd2, laddr(26, 0), '0);
      rq(3'd1, laddr(26, 0), 32'hDEAD);
      cyc(1'b1, 3'd1, laddr(27, 0), 32'h1, 1'b0, '0, 1'b1, 1'b0);
      chk(!s_ready && !s_ptv, "R12 request dropped", {s_ready, s_ptv}, 0);
      #2;
      chk(done && !success && restart && !cm_valid, "R12 abort outcome",
          {done, success, restart, cm_valid}, 4'b1010);
      @(posedge clk); #1;
      rq(3'd2, laddr(26, 0), '0);
      chk(s_rsp == memval(laddr(26, 0)), "R12 buffered write discarded",
          s_rsp, memval(laddr(26, 0)));
      cyc(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b1);
      #2;
      chk(done && restart && !success, "R12 privilege change", {done, restart, success}, 3'b110);
      @(posedge clk); #1;

      // R13 state cleared between events
      rq(3'd2, laddr(28, 0), '0);
      cyc(1'b0, 3'd0, '0, '0, 1'b1, laddr(22, 0), 1'b0, 1'b0);
      rq(3'd5, '0, '0);
      chk(!s_interf, "R13 old monitors cleared", s_interf, 0);
      rq(3'd4, laddr(28, 0), 32'hAB);
      #2;
      chk(success && cm_mask == 8'h01, "R13 fresh event commits", {success, cm_mask}, 9'h101);
      @(posedge clk); #1;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule